// File: doc/BRIEF.md
# Four-Channel Buffered PWM

This block drives four pulse-width-modulated outputs from a single clock, under control of a plain memory-mapped register bus. The bus has an address, write data, a write strobe, a read strobe and read data. Each channel has its own clock divider, a 16-bit period counter, a compare threshold and an output inversion bit. The compare threshold gives the length of the inactive part of each period. This means that every period opens at the inactive level and switches to the active level partway through.

While a channel runs, software retunes it through shadow registers. A value written to a shadow register stays pending until the running period wraps, so the waveform never shows a torn period. Disabling is also deferred to the end of the current period. The running-status bits show when the stop has completed. A global flag register records each period start per channel and empties when it is read.

Each channel is sequenced by a three-state machine. `CH_IDLE` goes to `CH_RUN` on an enable request. `CH_RUN` goes to `CH_DRAIN` on a disable request. If that disable request lands on the period's final tick, `CH_RUN` goes straight to `CH_IDLE`. `CH_DRAIN` goes to `CH_IDLE` at the period end. An enable request seen in `CH_DRAIN` returns the channel to `CH_RUN` and cancels the stop.

Top module: `pwm_quad`

## Requirements
- R1: After reset every output is low, the status and flag registers read 0, and every channel register reads 0.
- R2: Register map (byte addresses):
  - Global registers: enable at 0x004 (write one per channel bit), disable at 0x008 (write one per channel bit), running status at 0x00C (bit n = channel n), period-start flags at 0x01C.
  - Channel n occupies 0x200 + 32·n. Within that window: mode at 0x00, duty at 0x04, duty shadow at 0x08, period at 0x0C, period shadow at 0x10.
  - Mode fields: bits [3:0] are the divider exponent, bit 9 is the inversion bit, and bit 10 is a plain storage bit. These fields read back, and all other mode bits read 0.
  - Duty and period hold 16 bits.
- R3: With divider exponent N, period P and duty D, the counter advances once every 2^N clocks and wraps to 0 after reaching P−1. The non-inverted output is low while the count is below D and high otherwise. When D ≥ P the output stays low.
- R4: Divider exponents 11 to 15 behave exactly like 10.
- R5: Bit 9 inverts the output. A stopped channel drives the value of bit 9.
- R6: Enabling a stopped channel starts its count and divider phase from 0. The first clock after the enable write is count 0.
- R7: A shadow write is held pending and reads back from the shadow address. The pending value is copied into the working duty or period on the clock where the running period ends. Until then the working register and the waveform keep their old value.
- R8: While a channel's status bit is 1, writes to its mode, duty and period addresses are ignored. While the channel is stopped, those writes take effect at once.
- R9: After a disable write, the channel completes its current period with its status bit still 1. It then stops, clears its count and shows status 0.
- R10: A channel's flag bit is set when that channel is enabled from stop and at every later period start. Reading 0x01C returns all flags and clears them all. A flag set on the same clock as the read survives.
- R11: Enabling, configuring or stopping one channel leaves the outputs of the other channels unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one clock per write |
| bus_re | input | 1 | Read strobe; a read of the flags clears them |
| bus_rdata | output | 32 | Read data, valid in the same cycle as `bus_re` |
| pwm_out | output | 4 | Channel outputs |

## Verification
The waveform is swept on every channel over divider exponents 0 to 2, periods 3 and 4, every duty from 0 to P+1, and both polarities. The expected level is computed per clock from the elapsed cycle count. Together these patterns separate off-by-one faults in the compare, the wrap and the divider phase, and they show a wrong polarity or a never-active duty. Scripted sequences then place a shadow update, a deferred disable and a flag read on known cycles around a period end. These sequences expose loads or stops that happen one period early or late. A long run with exponent 15 checks the clamp at 10.

// File: rtl/pwm_quad_pkg.sv
package pwm_quad_pkg;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_RUN   = 2'd1,
        CH_DRAIN = 2'd2
    } ch_state_e;

    // channel window offsets
    localparam logic [4:0] OFF_MODE     = 5'h00;
    localparam logic [4:0] OFF_DUTY     = 5'h04;
    localparam logic [4:0] OFF_DUTY_SHD = 5'h08;
    localparam logic [4:0] OFF_PER      = 5'h0C;
    localparam logic [4:0] OFF_PER_SHD  = 5'h10;

    // global register addresses
    localparam int G_ENABLE  = 'h004;
    localparam int G_DISABLE = 'h008;
    localparam int G_STATUS  = 'h00C;
    localparam int G_FLAGS   = 'h01C;
    localparam int CH_BASE   = 'h200;

    localparam int MODE_POL_BIT = 9;
    localparam int MODE_AUX_BIT = 10;

endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
    parameter int PW   = 4,
    parameter int PMAX = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          run,
    input  logic [PW-1:0] sel,
    output logic          tick
);
    logic [PMAX-1:0] cnt;
    logic [PMAX-1:0] mask;
    logic [PMAX:0]   one_sh;
    logic [PW-1:0]   n_eff;

    always_comb begin
        n_eff  = (sel > PW'(PMAX)) ? PW'(PMAX) : sel;
        one_sh = (PMAX+1)'(1) << n_eff;
        mask   = one_sh[PMAX-1:0] - PMAX'(1);
        tick   = run && (cnt == mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt <= '0;
        else if (clr)    cnt <= '0;
        else if (run)    cnt <= tick ? '0 : cnt + PMAX'(1);
    end

    AST_PS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= mask)); // R4

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
    import pwm_quad_pkg::*;
#(
    parameter int CW   = 16,
    parameter int PW   = 4,
    parameter int PMAX = 10,
    parameter int DW   = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [4:0]    off,
    input  logic [DW-1:0] wdata,
    input  logic          en_req,
    input  logic          dis_req,
    output logic [DW-1:0] rdata,
    output logic          running,
    output logic          start,
    output logic          out
);
    ch_state_e     state, nxt;
    logic [PW-1:0] pre_sel;
    logic          pol, aux;
    logic [CW-1:0] duty, per, duty_shd, per_shd, cnt;
    logic          duty_pend, per_pend;
    logic          tick, last, idle;
    logic          unused_hi;

    assign unused_hi = ^wdata[DW-1:CW];
    assign idle      = (state == CH_IDLE);

    pwm_prescale #(.PW(PW), .PMAX(PMAX)) u_ps (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (idle || (nxt == CH_IDLE)),
        .run  (!idle),
        .sel  (pre_sel),
        .tick (tick)
    );

    assign last = tick && (({1'b0, cnt} + (CW+1)'(1)) >= {1'b0, per});

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            CH_IDLE:  nxt = en_req ? CH_RUN : CH_IDLE;
            CH_RUN:   if (dis_req) nxt = last ? CH_IDLE : CH_DRAIN;
            CH_DRAIN: begin
                if (en_req)    nxt = CH_RUN;
                else if (last) nxt = CH_IDLE;
            end
            default:  nxt = CH_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CH_IDLE;
        else        state <= nxt;
    end

    // counter and configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            pre_sel   <= '0;
            pol       <= 1'b0;
            aux       <= 1'b0;
            duty      <= '0;
            per       <= '0;
            duty_shd  <= '0;
            per_shd   <= '0;
            duty_pend <= 1'b0;
            per_pend  <= 1'b0;
        end else begin
            if (idle || nxt == CH_IDLE) cnt <= '0;
            else if (last)              cnt <= '0;
            else if (tick)              cnt <= cnt + CW'(1);

            if (!idle && last) begin
                if (duty_pend) begin
                    duty      <= duty_shd;
                    duty_pend <= 1'b0;
                end
                if (per_pend) begin
                    per      <= per_shd;
                    per_pend <= 1'b0;
                end
            end

            if (wr_en) begin
                case (off)
                    OFF_MODE: if (idle) begin
                        pre_sel <= wdata[PW-1:0];
                        pol     <= wdata[MODE_POL_BIT];
                        aux     <= wdata[MODE_AUX_BIT];
                    end
                    OFF_DUTY:     if (idle) duty <= wdata[CW-1:0];
                    OFF_PER:      if (idle) per  <= wdata[CW-1:0];
                    OFF_DUTY_SHD: begin
                        duty_shd  <= wdata[CW-1:0];
                        duty_pend <= 1'b1;
                    end
                    OFF_PER_SHD: begin
                        per_shd  <= wdata[CW-1:0];
                        per_pend <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        running = !idle;
        start   = (idle && en_req) || (!idle && last && nxt != CH_IDLE);
        out     = (!idle && (cnt >= duty)) ^ pol;
        rdata   = '0;
        case (off)
            OFF_MODE: begin
                rdata[PW-1:0]       = pre_sel;
                rdata[MODE_POL_BIT] = pol;
                rdata[MODE_AUX_BIT] = aux;
            end
            OFF_DUTY:     rdata = DW'(duty);
            OFF_DUTY_SHD: rdata = DW'(duty_shd);
            OFF_PER:      rdata = DW'(per);
            OFF_PER_SHD:  rdata = DW'(per_shd);
            default:      rdata = '0;
        endcase
    end

    AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |-> ((cnt < per) || (cnt == '0))); // R3
    AST_DUTY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && !last) |=> $stable(duty)); // R7
    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |=> $stable(pol)); // R8
    AST_DRAIN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_DRAIN && !last && !en_req) |=> running); // R9
    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(running) |-> (cnt == '0)); // R9

endmodule

// File: rtl/pwm_quad.sv
module pwm_quad
    import pwm_quad_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int CW   = 16,
    parameter int PW   = 4,
    parameter int PMAX = 10,
    parameter int AW   = 12,
    parameter int DW   = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [AW-1:0]  bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    input  logic           bus_we,
    input  logic           bus_re,
    output logic [DW-1:0]  bus_rdata,
    output logic [NCH-1:0] pwm_out
);
    localparam int STRIDE_LG = 5;
    localparam int SEL_W     = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int WIN_LO    = STRIDE_LG + SEL_W;

    logic             ch_hit;
    logic [SEL_W-1:0] ch_sel;
    logic [NCH-1:0]   en_v, dis_v, run_v, start_v, flags;
    logic             flag_rd;
    logic [DW-1:0]    ch_rd [NCH];

    always_comb begin
        ch_hit  = (bus_addr[AW-1:WIN_LO] == (AW-WIN_LO)'(CH_BASE >> WIN_LO));
        ch_sel  = bus_addr[WIN_LO-1:STRIDE_LG];
        en_v    = (bus_we && bus_addr == AW'(G_ENABLE))  ? bus_wdata[NCH-1:0] : '0;
        dis_v   = (bus_we && bus_addr == AW'(G_DISABLE)) ? bus_wdata[NCH-1:0] : '0;
        flag_rd = bus_re && (bus_addr == AW'(G_FLAGS));
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        pwm_chan #(.CW(CW), .PW(PW), .PMAX(PMAX), .DW(DW)) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (bus_we && ch_hit && (ch_sel == SEL_W'(g))),
            .off    (bus_addr[STRIDE_LG-1:0]),
            .wdata  (bus_wdata),
            .en_req (en_v[g]),
            .dis_req(dis_v[g]),
            .rdata  (ch_rd[g]),
            .running(run_v[g]),
            .start  (start_v[g]),
            .out    (pwm_out[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flag_rd ? '0 : flags) | start_v;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_re) begin
            if (ch_hit)                             bus_rdata = ch_rd[ch_sel];
            else if (bus_addr == AW'(G_STATUS))     bus_rdata = DW'(run_v);
            else if (bus_addr == AW'(G_FLAGS))      bus_rdata = DW'(flags);
        end
    end

    AST_FLAG_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (|start_v) |=> ((flags & $past(start_v)) == $past(start_v))); // R10
    AST_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        (|start_v) |=> ((run_v & $past(start_v)) == $past(start_v))); // R6

endmodule

// File: tb/sim_pwm_quad.sv
module sim_pwm_quad;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_out;

    int checks = 0;
    int errors = 0;
    int t = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pwm_quad u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    function automatic logic [11:0] ca(input int ch, input int off);
        return 12'(32'h200 + ch * 32 + off);
    endfunction

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s t=%0d got=%h exp=%h", tag, t, got, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        t++;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; t++;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] q);
        bus_addr = a; bus_re = 1'b1;
        #1 q = bus_rdata;
        @(negedge clk);
        bus_re = 1'b0; t++;
    endtask

    task automatic stop_ch(input int ch, input logic pol);
        logic [31:0] q;
        wr(12'h008, 32'(1 << ch));
        for (int k = 0; k < 3000; k++) begin
            rd(12'h00C, q);
            if (q[ch] == 1'b0) break;
        end
        chk(32'(q[ch]), 0, "R9 stop status");
        chk(32'(pwm_out[ch]), 32'(pol), "R5 idle level");
    endtask

    task automatic run_wave(input int ch, input int n, input int p, input int d, input int pol);
        int ncyc;
        logic e;
        wr(ca(ch, 0), 32'((pol << 9) | n));
        wr(ca(ch, 4), 32'(d));
        wr(ca(ch, 12), 32'(p));
        wr(12'h004, 32'(1 << ch));
        t = 0;
        ncyc = 2 * (p << n) + 3;
        for (int i = 0; i < ncyc; i++) begin
            e = ((((i >> n) % p) >= d) ? 1'b1 : 1'b0) ^ pol[0];
            chk(32'(pwm_out[ch]), 32'(e), (i == 0) ? "R6 first count" : "R3 wave");
            chk(32'(pwm_out & ~(4'(1) << ch)), 0, "R11 others idle");
            step();
        end
        stop_ch(ch, pol[0]);
        wr(ca(ch, 0), 0);
    endtask

    initial begin
        #(150000 * 4);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] q;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(32'(pwm_out), 0, "R1 outputs");
        rd(12'h00C, q); chk(q, 0, "R1 status");
        rd(12'h01C, q); chk(q, 0, "R1 flags");
        rd(ca(2, 12), q); chk(q, 0, "R1 period");

        // R2 readback
        wr(ca(3, 0), 32'hFFFF_FFFF);
        rd(ca(3, 0), q); chk(q, 32'h0000_060F, "R2 mode fields");
        wr(ca(3, 0), 0);
        wr(ca(3, 12), 32'h0001_2345);
        rd(ca(3, 12), q); chk(q, 32'h0000_2345, "R2 period width");

        // R3/R5/R6/R11 sweep
        for (int ch = 0; ch < 4; ch++)
            for (int n = 0; n < 3; n++)
                for (int p = 3; p < 5; p++)
                    for (int d = 0; d <= p + 1; d++)
                        for (int pol = 0; pol < 2; pol++)
                            run_wave(ch, n, p, d, pol);

        // R9 deferred stop
        wr(ca(0, 0), 0); wr(ca(0, 4), 2); wr(ca(0, 12), 5);
        wr(12'h004, 1);
        t = 0;
        step();
        wr(12'h008, 1);
        rd(12'h00C, q); chk(32'(q[0]), 1, "R9 still running 2");
        chk(32'(pwm_out[0]), 1, "R9 active 3");
        rd(12'h00C, q); chk(32'(q[0]), 1, "R9 still running 3");
        chk(32'(pwm_out[0]), 1, "R9 active 4");
        rd(12'h00C, q); chk(32'(q[0]), 1, "R9 still running 4");
        rd(12'h00C, q); chk(32'(q[0]), 0, "R9 stopped at end");
        chk(32'(pwm_out[0]), 0, "R9 inactive after stop");

        // R7 shadow updates on channel 1
        wr(ca(1, 0), 0); wr(ca(1, 4), 1); wr(ca(1, 12), 4);
        wr(12'h004, 2);
        t = 0;
        chk(32'(pwm_out[1]), 0, "R7 count0");
        step();
        wr(ca(1, 8), 3);
        chk(32'(pwm_out[1]), 1, "R7 old duty holds");
        rd(ca(1, 4), q); chk(q, 1, "R7 working unchanged");
        rd(ca(1, 8), q); chk(q, 3, "R7 shadow readback");
        while (t < 8) begin
            chk(32'(pwm_out[1]), 32'(((t - 4) >= 3) ? 1 : 0), "R7 new duty");
            step();
        end
        rd(ca(1, 4), q); chk(q, 3, "R7 duty loaded");
        wr(ca(1, 16), 6);
        while (t < 19) begin
            chk(32'(pwm_out[1]),
                32'((t < 12) ? (((t % 4) >= 3) ? 1 : 0) : ((((t - 12) % 6) >= 3) ? 1 : 0)),
                "R7 period load");
            step();
        end

        // R8 writes while running / stopped
        wr(ca(1, 0), 32'h200);
        rd(ca(1, 0), q); chk(q, 0, "R8 mode ignored");
        wr(ca(1, 4), 0);
        rd(ca(1, 4), q); chk(q, 3, "R8 duty ignored");
        rd(ca(1, 12), q); chk(q, 6, "R8 period kept");
        stop_ch(1, 1'b0);
        wr(ca(1, 4), 7);
        rd(ca(1, 4), q); chk(q, 7, "R8 duty accepted stopped");

        // R4 clamp
        wr(ca(2, 0), 15); wr(ca(2, 4), 1); wr(ca(2, 12), 2);
        wr(12'h004, 4);
        t = 0;
        while (t <= 2048) begin
            if (t == 0 || t == 1023 || t == 1024 || t == 2047 || t == 2048)
                chk(32'(pwm_out[2]), 32'(((t >> 10) % 2) >= 1 ? 1 : 0), "R4 clamp");
            step();
        end
        stop_ch(2, 1'b0);
        wr(ca(2, 0), 0);

        // R10 flags
        rd(12'h01C, q);
        wr(ca(0, 4), 1); wr(ca(0, 12), 4);
        wr(ca(3, 0), 0); wr(ca(3, 4), 2); wr(ca(3, 12), 4);
        wr(12'h004, 32'h9);
        t = 0;
        rd(12'h01C, q); chk(q, 32'h9, "R10 set on enable");
        rd(12'h01C, q); chk(q, 0, "R10 cleared by read");
        while (t < 4) step();
        chk(32'(pwm_out[1]), 0, "R11 ch1 idle");
        rd(12'h01C, q); chk(q, 32'h9, "R10 period start");
        while (t < 7) step();
        rd(12'h01C, q); chk(q, 0, "R10 none mid-period");
        rd(12'h01C, q); chk(q, 32'h9, "R10 set wins over clear");
        stop_ch(0, 1'b0);
        stop_ch(3, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule